// File: doc/BRIEF.md
# Serial Control Word Receiver with Addressed Register Commit

This block takes configuration for an audio playback path over three wires: a serial data line, a shift clock and a commit strobe. The host shifts a 24-bit word in, most significant bit first. The first 16 bits are a data field and the last 8 bits are a target address. A rising edge on the commit strobe writes the data field into one of two configuration registers. The trailing address selects which register is written.

The first register sets the output attenuation level, turns de-emphasis on or off, and mutes the output. The second register sets the serial sample layout (bit order and word width) and selects the sample rate that the de-emphasis filter uses. Both registers drive parallel outputs. The downstream audio logic reads these outputs directly.

All three serial lines are asynchronous to the block clock `clk`. Each line passes through a synchronizer, and edges are detected in the `clk` domain. The serial clock must therefore be much slower than `clk`.

Top module: `ctrl_word_port`

## Requirements
- R1: While `rst_n` is low, and after it is released, the outputs hold their defaults: `atten_level`=0, `deemph_en`=0, `mute_en`=0, `lsb_first`=0 (MSB first), `fmt_16bit`=0 (20-bit) and `deemph_rate`=00. An asserted reset returns the outputs to these defaults from any state.
- R2: `ctl_sdata` is sampled on each rising edge of `ctl_sclk`, and the word is assembled MSB first. Of the 24 bits, the first 16 received form the data field (data bit 15 first). The last 8 received form the address.
- R3: Shifting bits alone never changes an output. Outputs change only on a commit.
- R4: A commit with address 0x40 loads the attenuation register with data bits [7:0] as `atten_level`, bit 8 as `deemph_en` and bit 9 as `mute_en`. Other data bits are ignored.
- R5: A commit with address 0x41 loads the system register with data bit 0 as `lsb_first`, bit 1 as `fmt_16bit` and bits [3:2] as `deemph_rate` (00 = 44.1 kHz, 01 = 48 kHz, 10 = 32 kHz). The code 11 is reserved: it leaves `deemph_rate` unchanged, but bits 0 and 1 are still written.
- R6: A commit with any other address leaves every output unchanged.
- R7: If fewer or more than 24 bits arrive before a commit, the commit uses the last 24 bits received since reset. When fewer than 24 bits have arrived since reset, the missing positions read as zero.
- R8: With the default two-stage synchronizer, outputs update on the third rising edge of `clk` after `ctl_latch` rises. Each strobe edge produces exactly one commit.
- R9: Holding `ctl_latch` high does not repeat the commit. Bits shifted while the strobe is high are committed only by the next rising edge of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_sclk | input | 1 | Serial shift clock, sampled in the clk domain |
| ctl_sdata | input | 1 | Serial data line, MSB first |
| ctl_latch | input | 1 | Commit strobe, acts on its rising edge |
| atten_level | output | 8 | Attenuation step |
| deemph_en | output | 1 | De-emphasis enable |
| mute_en | output | 1 | Soft mute select |
| lsb_first | output | 1 | Sample bit order: 1 = LSB first |
| fmt_16bit | output | 1 | Sample width: 1 = 16-bit, 0 = 20-bit |
| deemph_rate | output | 2 | De-emphasis rate code |

## Verification
A corrupted shift register only appears at the ports on the next commit. It then shows as a wrong field value or as a write to the wrong register, so each commit acts as the point where the shift state is observed. A fault in the edge detector or in address decode appears within three `clk` cycles of the strobe edge. It shows either as an output that changes early or late, or as an output that changes when it should have held. The reference model compares every output on every clock, so a drift in commit timing or a spurious write is caught in the cycle it happens.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam int WORD_W = DATA_W + ADDR_W;
  localparam int ATT_W  = 8;
  localparam int RATE_W = 2;
  localparam int DEEMPH_BIT = ATT_W;
  localparam int MUTE_BIT   = ATT_W + 1;
  localparam int RATE_LSB   = 2;

  typedef enum logic [RATE_W-1:0] {
    RATE_44K1 = 2'b00,
    RATE_48K  = 2'b01,
    RATE_32K  = 2'b10,
    RATE_RSVD = 2'b11
  } rate_e;

  typedef struct packed {
    logic             mute;
    logic             deemph;
    logic [ATT_W-1:0] level;
  } atten_reg_t;

  typedef struct packed {
    rate_e rate;
    logic  fmt16;
    logic  lsb_first;
  } sys_reg_t;

  localparam atten_reg_t ATTEN_RST = '{mute: 1'b0, deemph: 1'b0, level: '0};
  localparam sys_reg_t   SYS_RST   = '{rate: RATE_44K1, fmt16: 1'b0, lsb_first: 1'b0};

  function automatic logic [ADDR_W-1:0] word_addr(input logic [WORD_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] word_data(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:ADDR_W];
  endfunction

  function automatic atten_reg_t decode_atten(input logic [DATA_W-1:0] d);
    atten_reg_t r;
    r.level  = d[ATT_W-1:0];
    r.deemph = d[DEEMPH_BIT];
    r.mute   = d[MUTE_BIT];
    return r;
  endfunction

  function automatic logic rate_legal(input logic [RATE_W-1:0] code);
    return code != RATE_RSVD;
  endfunction

  function automatic sys_reg_t decode_sys(input logic [DATA_W-1:0] d,
                                          input sys_reg_t          prev);
    sys_reg_t r;
    r.lsb_first = d[0];
    r.fmt16     = d[1];
    r.rate      = rate_legal(d[RATE_LSB +: RATE_W]) ?
                  rate_e'(d[RATE_LSB +: RATE_W]) : prev.rate;
    return r;
  endfunction
endpackage

// File: rtl/cwp_sync.sv
module cwp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= din;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cwp_edge.sv
module cwp_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic lvl;
  logic lvl_d;

  cwp_sync #(.STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst_n(rst_n),
    .din (din),
    .dout(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R8
endmodule

// File: rtl/cwp_shift.sv
module cwp_shift
  import cwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> word[0] == $past(bit_in)); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word)); // R7
endmodule

// File: rtl/cwp_regbank.sv
module cwp_regbank
  import cwp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ADDR_ATT = 8'h40,
  parameter logic [ADDR_W-1:0] ADDR_SYS = 8'h41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output atten_reg_t        atten_q,
  output sys_reg_t          sys_q
);
  logic hit_att;
  logic hit_sys;
  logic [DATA_W-1:0] data;

  assign data    = word_data(word);
  assign hit_att = commit && (word_addr(word) == ADDR_ATT);
  assign hit_sys = commit && (word_addr(word) == ADDR_SYS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       atten_q <= ATTEN_RST;
    else if (hit_att) atten_q <= decode_atten(data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sys_q <= SYS_RST;
    else if (hit_sys) sys_q <= decode_sys(data, sys_q);
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(atten_q) && $stable(sys_q)); // R3
  AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !hit_att && !hit_sys) |=> $stable(atten_q) && $stable(sys_q)); // R6
  AST_ATT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    hit_att |=> atten_q.level == $past(word[ADDR_W +: ATT_W])); // R4
  AST_ATT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    hit_att |=> $stable(sys_q)); // R4
  AST_RATE_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_sys && word[ADDR_W+RATE_LSB +: RATE_W] == 2'b11) |=> $stable(sys_q.rate)); // R5
  AST_SYS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    hit_sys |=> $stable(atten_q)); // R5
endmodule

// File: rtl/ctrl_word_port.sv
module ctrl_word_port
  import cwp_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ADDR_ATT    = 8'h40,
  parameter logic [ADDR_W-1:0] ADDR_SYS    = 8'h41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_sclk,
  input  logic              ctl_sdata,
  input  logic              ctl_latch,
  output logic [ATT_W-1:0]  atten_level,
  output logic              deemph_en,
  output logic              mute_en,
  output logic              lsb_first,
  output logic              fmt_16bit,
  output logic [RATE_W-1:0] deemph_rate
);
  logic              shift_pulse;
  logic              commit_pulse;
  logic              sdata_s;
  logic [WORD_W-1:0] shift_word;
  atten_reg_t        atten_q;
  sys_reg_t          sys_q;

  cwp_edge #(.STAGES(SYNC_STAGES)) u_sclk_edge (
    .clk (clk), .rst_n(rst_n), .din(ctl_sclk), .rise(shift_pulse)
  );

  cwp_edge #(.STAGES(SYNC_STAGES)) u_latch_edge (
    .clk (clk), .rst_n(rst_n), .din(ctl_latch), .rise(commit_pulse)
  );

  cwp_sync #(.STAGES(SYNC_STAGES)) u_data_sync (
    .clk (clk), .rst_n(rst_n), .din(ctl_sdata), .dout(sdata_s)
  );

  cwp_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_pulse),
    .bit_in  (sdata_s),
    .word    (shift_word)
  );

  cwp_regbank #(.ADDR_ATT(ADDR_ATT), .ADDR_SYS(ADDR_SYS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit_pulse),
    .word   (shift_word),
    .atten_q(atten_q),
    .sys_q  (sys_q)
  );

  assign atten_level = atten_q.level;
  assign deemph_en   = atten_q.deemph;
  assign mute_en     = atten_q.mute;
  assign lsb_first   = sys_q.lsb_first;
  assign fmt_16bit   = sys_q.fmt16;
  assign deemph_rate = sys_q.rate;

  AST_NO_CROSS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(($changed(atten_q)) && ($changed(sys_q)))); // R6
endmodule

// File: tb/ctrl_word_port_tb.sv
module ctrl_word_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_sclk = 1'b0, ctl_sdata = 1'b0, ctl_latch = 1'b0;
  logic [7:0] atten_level;
  logic deemph_en, mute_en, lsb_first, fmt_16bit;
  logic [1:0] deemph_rate;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit cmp_on = 0;

  // behavioural model state
  bit   m_bits[$];
  int   m_level = 0, m_rate = 0;
  bit   m_deemph = 0, m_mute = 0, m_lsb = 0, m_f16 = 0;

  always #5 clk = ~clk;

  ctrl_word_port u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_sclk(ctl_sclk), .ctl_sdata(ctl_sdata),
    .ctl_latch(ctl_latch), .atten_level(atten_level), .deemph_en(deemph_en),
    .mute_en(mute_en), .lsb_first(lsb_first), .fmt_16bit(fmt_16bit),
    .deemph_rate(deemph_rate)
  );

  function automatic int exp_vec();
    return (m_level << 6) | (int'(m_deemph) << 5) | (int'(m_mute) << 4) |
           (int'(m_lsb) << 3) | (int'(m_f16) << 2) | m_rate;
  endfunction

  function automatic int act_vec();
    return (int'(atten_level) << 6) | (int'(deemph_en) << 5) | (int'(mute_en) << 4) |
           (int'(lsb_first) << 3) | (int'(fmt_16bit) << 2) | int'(deemph_rate);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (cmp_on && rst_n) check("R3/R8 per-clock compare", act_vec(), exp_vec());

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic model_reset();
    m_bits.delete();
    for (int i = 0; i < 24; i++) m_bits.push_back(1'b0);
    m_level = 0; m_rate = 0; m_deemph = 0; m_mute = 0; m_lsb = 0; m_f16 = 0;
  endtask

  task automatic model_commit();
    int w = 0, addr, data;
    for (int i = 0; i < 24; i++) w = (w * 2) + int'(m_bits[i]);
    addr = w % 256;
    data = w / 256;
    if (addr == 64) begin
      m_level = data % 256;
      m_deemph = ((data / 256) % 2) == 1;
      m_mute = ((data / 512) % 2) == 1;
    end else if (addr == 65) begin
      m_lsb = (data % 2) == 1;
      m_f16 = ((data / 2) % 2) == 1;
      if (((data / 4) % 4) != 3) m_rate = (data / 4) % 4;
    end
  endtask

  task automatic send_bits(input int value, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      ctl_sdata = ((value >> i) & 1) == 1;
      repeat (3) @(negedge clk);
      ctl_sclk = 1'b1;
      m_bits.push_back(ctl_sdata);
      void'(m_bits.pop_front());
      repeat (4) @(negedge clk);
      ctl_sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic latch_rise(input bit lat_chk);
    @(negedge clk);
    ctl_latch = 1'b1;
    @(posedge clk); @(posedge clk);
    if (lat_chk) begin
      @(negedge clk);
      check("R8 no update before third edge", act_vec(), exp_vec());
    end
    @(posedge clk);
    model_commit();
    repeat (3) @(negedge clk);
  endtask

  task automatic latch_fall();
    @(negedge clk);
    ctl_latch = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_word(input int data, input int addr);
    send_bits((data << 8) | addr, 24);
    latch_rise(1'b0);
    latch_fall();
  endtask

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    check("R1 outputs during reset", act_vec(), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 defaults after reset", act_vec(), 0);
    cmp_on = 1;

    // R2 R3 R4 R8: attenuation write with latency check
    send_bits((16'h02A5 << 8) | 8'h40, 24);
    check("R3 shifting alone leaves outputs", act_vec(), 0);
    latch_rise(1'b1);
    latch_fall();
    check("R4 level", int'(atten_level), 8'hA5);
    check("R4 mute bit9", int'(mute_en), 1);
    check("R4 deemph bit8", int'(deemph_en), 0);
    check("R2 MSB-first word assembly", act_vec(), exp_vec());

    // R5 system write
    write_word(16'h0007, 8'h41);
    check("R5 lsb_first", int'(lsb_first), 1);
    check("R5 fmt_16bit", int'(fmt_16bit), 1);
    check("R5 rate 48k code", int'(deemph_rate), 1);
    check("R4 attenuation untouched by system write", int'(atten_level), 8'hA5);

    // R5 reserved rate code
    write_word(16'h000C, 8'h41);
    check("R5 reserved rate holds", int'(deemph_rate), 1);
    check("R5 other bits still written", int'(lsb_first) + int'(fmt_16bit), 0);

    write_word(16'h0108, 8'h40);
    check("R4 deemph set, mute cleared", act_vec(), exp_vec());
    check("R4 deemph bit", int'(deemph_en), 1);
    write_word(16'h0008, 8'h41);
    check("R5 rate 32k code", int'(deemph_rate), 2);

    // R6 foreign address
    write_word(16'hFFFF, 8'h42);
    check("R6 foreign address ignored", act_vec(), exp_vec());
    check("R6 level unchanged", int'(atten_level), 8'h08);

    // R7 short word: last 24 bits = FF42_40
    send_bits(8'h40, 8);
    latch_rise(1'b0);
    latch_fall();
    check("R7 short word level", int'(atten_level), 8'h42);
    check("R7 short word flags", int'(deemph_en) + int'(mute_en), 2);

    // R7 long word: 6 junk bits then valid word
    send_bits(6'b101101, 6);
    send_bits((16'h0033 << 8) | 8'h40, 24);
    latch_rise(1'b0);
    latch_fall();
    check("R7 long word level", int'(atten_level), 8'h33);

    // R9 strobe held high
    send_bits((16'h0011 << 8) | 8'h40, 24);
    latch_rise(1'b0);
    check("R9 first commit", int'(atten_level), 8'h11);
    send_bits((16'h0022 << 8) | 8'h40, 24);
    check("R9 no repeat while strobe high", int'(atten_level), 8'h11);
    latch_fall();
    latch_rise(1'b0);
    latch_fall();
    check("R9 next rise commits", int'(atten_level), 8'h22);

    // R1 reset mid-operation
    @(negedge clk);
    cmp_on = 0;
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R1 reset clears state", act_vec(), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    repeat (3) @(negedge clk);
    send_bits(8'h40, 8);
    latch_rise(1'b0);
    latch_fall();
    check("R7 zeros fill after reset", act_vec(), 0);

    cmp_on = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule